// File: doc/BRIEF.md
# Two-Bank DRAM Access Sequencer

This block turns a processor bus cycle into the row/column strobe sequence of a dynamic memory array split into two banks. When the address-latch-enable input falls, the block samples an active-low chip select. If that select is asserted, it captures a 16-bit address and a bank-select bit and then starts a cycle. It first puts the upper address byte on an 8-bit multiplexed memory bus. One clock later it asserts the row strobe of the selected bank.

The processor then pulls either its read or its write access-control input low. The block answers by switching the bus to the lower address byte and asserting the shared column strobe. It holds both strobes until the access control returns high, and the cycle ends on that rising edge, not after a fixed count. If both access controls are low together, the address bus and every strobe are floated. Each output group has its own enable for this.

A wait strap inserts wait states into each cycle by holding ready low. A separate refresh controller reports refresh activity. A cycle requested during a refresh is stalled with ready low until the refresh completes.

Top module: `dram_access_seq`

## Requirements
- R1: After reset both row strobes and the column strobe are high, ready is high, all three output enables are high and the address bus reads 0.
- R2: Chip select is sampled only at the clock edge that first sees address-latch-enable low after it was high. A cycle starts only if chip select is low at that edge, whatever its level earlier in the latch pulse.
- R3: In the clock after the latch-enable fall is sampled, the address bus carries address bits [15:8] and no strobe is asserted. One clock later the selected row strobe goes low and the bus still carries bits [15:8].
- R4: Bank select 0 asserts row strobe bit 0 and bank select 1 asserts row strobe bit 1. The other row strobe stays high, and at most one row strobe is ever low.
- R5: The column phase is entered at the first clock edge that samples read or write access control low while a row strobe is already asserted. After that edge the bus carries address bits [7:0] and the column strobe is low. The column strobe is never low unless a row strobe was low in the clock before it fell.
- R6: The first clock edge that samples both access controls high while the column strobe is low negates the column strobe and the row strobe after that edge, and the block returns to idle.
- R7: At each clock edge that samples both access controls low, all three output enables (address bus, row strobes, column strobe) go low after that edge. They go high again after the first edge that samples either control high. The cycle state is unaffected.
- R8: If the wait strap is high when a cycle starts, ready is low for exactly NUM_WAIT clocks (default 1), beginning in the row-address clock. If the strap is low, ready stays high.
- R9: A cycle requested while refresh-busy is high holds ready low and all row strobes high. The cycle proceeds as in R3 (with R8 applied) after the first edge that samples refresh-busy low.
- R10: A latch-enable fall while a cycle is already running is ignored. The bus keeps the current address, and no second cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale_i | input | 1 | Address latch enable; its falling edge samples a request |
| cs_n_i | input | 1 | Active-low chip select |
| bank_sel_i | input | 1 | Bank choice for the row strobe |
| addr_i | input | 16 | Processor address, row in [15:8], column in [7:0] |
| acc_rd_n_i | input | 1 | Active-low read access control |
| acc_wr_n_i | input | 1 | Active-low write access control |
| wait_strap_i | input | 1 | High inserts wait states into each cycle |
| refresh_busy_i | input | 1 | High while the refresh controller owns the array |
| mem_addr_o | output | 8 | Multiplexed row/column address |
| mem_addr_oe_o | output | 1 | Drive enable of the address bus |
| ras_n_o | output | 2 | Active-low row strobes, one per bank |
| ras_oe_o | output | 1 | Drive enable of the row strobes |
| cas_n_o | output | 1 | Active-low column strobe |
| cas_oe_o | output | 1 | Drive enable of the column strobe |
| ready_o | output | 1 | Low stalls the processor |

## Verification
The assertions check the following properties on every clock:
- At most one bank strobe is active.
- The column strobe is asserted only under a row strobe, and only after a row strobe has already been held for a clock.
- The output enables follow the sampled access-control pair.
- Both strobes drop once the access control is released.

The bench scenarios show what a property cannot capture without restating the sequencer. This covers:
- the exact address byte in each phase;
- the bank each captured select drives;
- the length of the wait-state window;
- the stall during refresh;
- sampling chip select only at the latch fall;
- ignoring a second latch pulse in mid-cycle.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    // Sequencer phases of one access cycle
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for a latched request
        ST_HOLD = 3'd1,   // request parked behind a refresh
        ST_ROW  = 3'd2,   // row byte on the bus, strobes high
        ST_RAS  = 3'd3,   // row strobe asserted
        ST_COL  = 3'd4    // column byte on the bus, column strobe asserted
    } seq_state_e;

endpackage

// File: rtl/dram_seq_edge.sv
module dram_seq_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] prev_d;
    logic [W-1:0] prev_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_comb begin
            prev_d[g] = sig_i[g];
            fall_o[g] = prev_q[g] & ~sig_i[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= prev_d[g];
            end
        end
    end

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
    import dram_seq_pkg::*;
#(
    parameter int MA_W     = 8,
    parameter int BANKS    = 2,
    parameter int NUM_WAIT = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ale_fall_i,
    input  logic                 cs_n_i,
    input  logic [((BANKS > 1) ? $clog2(BANKS) : 1)-1:0] bank_sel_i,
    input  logic [2*MA_W-1:0]    addr_i,
    input  logic                 acc_rd_n_i,
    input  logic                 acc_wr_n_i,
    input  logic                 wait_strap_i,
    input  logic                 refresh_busy_i,
    output seq_state_e           nxt_st_o,
    output logic [((BANKS > 1) ? $clog2(BANKS) : 1)-1:0] nxt_bank_o,
    output logic [MA_W-1:0]      nxt_row_o,
    output logic [MA_W-1:0]      nxt_col_o,
    output logic                 nxt_wait_o
);

    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;
    localparam int CNT_W  = $clog2(NUM_WAIT + 1);
    localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(NUM_WAIT);

    typedef struct packed {
        seq_state_e        st;
        logic [BANK_W-1:0] bank;
        logic [MA_W-1:0]   row;
        logic [MA_W-1:0]   col;
        logic              ws;
        logic [CNT_W-1:0]  wcnt;
    } fsm_t;

    fsm_t d;
    fsm_t q;
    logic acc_low;

    always_comb begin
        d       = q;
        acc_low = !acc_rd_n_i || !acc_wr_n_i;
        if (q.wcnt != '0) begin
            d.wcnt = q.wcnt - CNT_W'(1);
        end
        case (q.st)
            ST_IDLE: begin
                if (ale_fall_i && !cs_n_i) begin
                    d.bank = bank_sel_i;
                    d.row  = addr_i[2*MA_W-1:MA_W];
                    d.col  = addr_i[MA_W-1:0];
                    d.ws   = wait_strap_i;
                    if (refresh_busy_i) begin
                        d.st = ST_HOLD;
                    end else begin
                        d.st   = ST_ROW;
                        d.wcnt = wait_strap_i ? WAIT_LOAD : '0;
                    end
                end
            end
            ST_HOLD: begin
                if (!refresh_busy_i) begin
                    d.st   = ST_ROW;
                    d.wcnt = q.ws ? WAIT_LOAD : '0;
                end
            end
            ST_ROW: d.st = ST_RAS;
            ST_RAS: begin
                if (acc_low) begin
                    d.st = ST_COL;
                end
            end
            ST_COL: begin
                if (!acc_low) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign nxt_st_o   = d.st;
    assign nxt_bank_o = d.bank;
    assign nxt_row_o  = d.row;
    assign nxt_col_o  = d.col;
    assign nxt_wait_o = (d.wcnt != '0);

endmodule

// File: rtl/dram_seq_drive.sv
module dram_seq_drive
    import dram_seq_pkg::*;
#(
    parameter int MA_W  = 8,
    parameter int BANKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  seq_state_e           nxt_st_i,
    input  logic [((BANKS > 1) ? $clog2(BANKS) : 1)-1:0] nxt_bank_i,
    input  logic [MA_W-1:0]      nxt_row_i,
    input  logic [MA_W-1:0]      nxt_col_i,
    input  logic                 nxt_wait_i,
    input  logic                 acc_rd_n_i,
    input  logic                 acc_wr_n_i,
    output logic [MA_W-1:0]      mem_addr_o,
    output logic                 mem_addr_oe_o,
    output logic [BANKS-1:0]     ras_n_o,
    output logic                 ras_oe_o,
    output logic                 cas_n_o,
    output logic                 cas_oe_o,
    output logic                 ready_o
);

    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;

    typedef struct packed {
        logic [MA_W-1:0]  addr;
        logic [BANKS-1:0] ras_n;
        logic             cas_n;
        logic             a_oe;
        logic             r_oe;
        logic             c_oe;
        logic             rdy;
    } drv_t;

    drv_t             d;
    drv_t             q;
    logic [BANKS-1:0] ras_sel;
    logic             row_live;
    logic             floating;

    assign row_live = (nxt_st_i == ST_RAS) || (nxt_st_i == ST_COL);

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        assign ras_sel[g] = row_live && (nxt_bank_i == BANK_W'(g));
    end

    always_comb begin
        floating = !acc_rd_n_i && !acc_wr_n_i;
        d        = q;
        case (nxt_st_i)
            ST_COL:         d.addr = nxt_col_i;
            ST_ROW, ST_RAS: d.addr = nxt_row_i;
            default:        d.addr = '0;
        endcase
        d.ras_n = ~ras_sel;
        d.cas_n = (nxt_st_i != ST_COL);
        d.a_oe  = !floating;
        d.r_oe  = !floating;
        d.c_oe  = !floating;
        d.rdy   = (nxt_st_i != ST_HOLD) && !nxt_wait_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{addr: '0, ras_n: '1, default: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign mem_addr_o    = q.addr;
    assign mem_addr_oe_o = q.a_oe;
    assign ras_n_o       = q.ras_n;
    assign ras_oe_o      = q.r_oe;
    assign cas_n_o       = q.cas_n;
    assign cas_oe_o      = q.c_oe;
    assign ready_o       = q.rdy;

endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
    import dram_seq_pkg::*;
#(
    parameter int MA_W     = 8,
    parameter int BANKS    = 2,
    parameter int NUM_WAIT = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ale_i,
    input  logic                 cs_n_i,
    input  logic [((BANKS > 1) ? $clog2(BANKS) : 1)-1:0] bank_sel_i,
    input  logic [2*MA_W-1:0]    addr_i,
    input  logic                 acc_rd_n_i,
    input  logic                 acc_wr_n_i,
    input  logic                 wait_strap_i,
    input  logic                 refresh_busy_i,
    output logic [MA_W-1:0]      mem_addr_o,
    output logic                 mem_addr_oe_o,
    output logic [BANKS-1:0]     ras_n_o,
    output logic                 ras_oe_o,
    output logic                 cas_n_o,
    output logic                 cas_oe_o,
    output logic                 ready_o
);

    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;

    logic              ale_fall;
    seq_state_e        nxt_st;
    logic [BANK_W-1:0] nxt_bank;
    logic [MA_W-1:0]   nxt_row;
    logic [MA_W-1:0]   nxt_col;
    logic              nxt_wait;

    dram_seq_edge #(
        .W (1)
    ) i_ale_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (ale_i),
        .fall_o (ale_fall)
    );

    dram_seq_fsm #(
        .MA_W     (MA_W),
        .BANKS    (BANKS),
        .NUM_WAIT (NUM_WAIT)
    ) i_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .ale_fall_i     (ale_fall),
        .cs_n_i         (cs_n_i),
        .bank_sel_i     (bank_sel_i),
        .addr_i         (addr_i),
        .acc_rd_n_i     (acc_rd_n_i),
        .acc_wr_n_i     (acc_wr_n_i),
        .wait_strap_i   (wait_strap_i),
        .refresh_busy_i (refresh_busy_i),
        .nxt_st_o       (nxt_st),
        .nxt_bank_o     (nxt_bank),
        .nxt_row_o      (nxt_row),
        .nxt_col_o      (nxt_col),
        .nxt_wait_o     (nxt_wait)
    );

    dram_seq_drive #(
        .MA_W  (MA_W),
        .BANKS (BANKS)
    ) i_drive (
        .clk           (clk),
        .rst_n         (rst_n),
        .nxt_st_i      (nxt_st),
        .nxt_bank_i    (nxt_bank),
        .nxt_row_i     (nxt_row),
        .nxt_col_i     (nxt_col),
        .nxt_wait_i    (nxt_wait),
        .acc_rd_n_i    (acc_rd_n_i),
        .acc_wr_n_i    (acc_wr_n_i),
        .mem_addr_o    (mem_addr_o),
        .mem_addr_oe_o (mem_addr_oe_o),
        .ras_n_o       (ras_n_o),
        .ras_oe_o      (ras_oe_o),
        .cas_n_o       (cas_n_o),
        .cas_oe_o      (cas_oe_o),
        .ready_o       (ready_o)
    );

endmodule

// File: rtl/dram_access_seq_chk.sv
module dram_access_seq_chk #(
    parameter int BANKS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_rd_n_i,
    input logic             acc_wr_n_i,
    input logic [BANKS-1:0] ras_n_o,
    input logic             cas_n_o,
    input logic             mem_addr_oe_o,
    input logic             ras_oe_o,
    input logic             cas_oe_o
);

    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ras_n_o) <= 1); // R4

    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n_o |-> !(&ras_n_o)); // R5

    AST_RAS_LEADS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n_o) |-> $past(!(&ras_n_o))); // R5

    AST_FLOAT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_rd_n_i && !acc_wr_n_i) |=> (!mem_addr_oe_o && !ras_oe_o && !cas_oe_o)); // R7

    AST_DRIVE_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd_n_i || acc_wr_n_i) |=> (mem_addr_oe_o && ras_oe_o && cas_oe_o)); // R7

    AST_END_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n_o && acc_rd_n_i && acc_wr_n_i) |=> (cas_n_o && (&ras_n_o))); // R6

endmodule

bind dram_access_seq dram_access_seq_chk #(
    .BANKS (BANKS)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_rd_n_i    (acc_rd_n_i),
    .acc_wr_n_i    (acc_wr_n_i),
    .ras_n_o       (ras_n_o),
    .cas_n_o       (cas_n_o),
    .mem_addr_oe_o (mem_addr_oe_o),
    .ras_oe_o      (ras_oe_o),
    .cas_oe_o      (cas_oe_o)
);

// File: tb/test_dram_access_seq.sv
`timescale 1ns/1ps
module test_dram_access_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ale, cs_n, bank_sel, rd_n, wr_n, ws, refb;
    logic [15:0] addr;
    logic [7:0]  mem_addr;
    logic        a_oe, r_oe, c_oe, cas_n, ready;
    logic [1:0]  ras_n;
    int          n_checks = 0;
    int          n_err    = 0;

    always #10 clk = ~clk;

    dram_access_seq i_dram_access_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .ale_i          (ale),
        .cs_n_i         (cs_n),
        .bank_sel_i     (bank_sel),
        .addr_i         (addr),
        .acc_rd_n_i     (rd_n),
        .acc_wr_n_i     (wr_n),
        .wait_strap_i   (ws),
        .refresh_busy_i (refb),
        .mem_addr_o     (mem_addr),
        .mem_addr_oe_o  (a_oe),
        .ras_n_o        (ras_n),
        .ras_oe_o       (r_oe),
        .cas_n_o        (cas_n),
        .cas_oe_o       (c_oe),
        .ready_o        (ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_idle(input string req);
        chk(req, {30'd0, ras_n}, 32'h3);
        chk(req, {31'd0, cas_n}, 32'h1);
        chk(req, {31'd0, ready}, 32'h1);
    endtask

    // One access cycle; flt exercises floating, again exercises a mid-cycle latch pulse
    task automatic do_cycle(input logic [15:0] a, input logic bk, input logic wst,
                            input logic use_wr, input int ref_clks,
                            input logic flt, input logic again);
        logic [1:0] ras_exp;
        ras_exp = bk ? 2'b01 : 2'b10;
        @(negedge clk);
        ale = 1'b1; cs_n = 1'b0; addr = a; bank_sel = bk; ws = wst; refb = (ref_clks > 0);
        @(negedge clk);
        ale = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; addr = ~a; bank_sel = ~bk; ws = ~wst;
        for (int i = 0; i < ref_clks; i++) begin
            chk("R9 ready during refresh", {31'd0, ready}, 32'h0);
            chk("R9 no row strobe during refresh", {30'd0, ras_n}, 32'h3);
            if (i == ref_clks - 1) refb = 1'b0;
            @(negedge clk);
        end
        chk("R3 row byte", {24'd0, mem_addr}, {24'd0, a[15:8]});
        chk("R3 strobes idle in row clock", {29'd0, ras_n, cas_n}, 32'h7);
        chk("R8 ready in row clock", {31'd0, ready}, {31'd0, ~wst});
        @(negedge clk);
        chk("R4 bank strobe", {30'd0, ras_n}, {30'd0, ras_exp});
        chk("R3 row byte held", {24'd0, mem_addr}, {24'd0, a[15:8]});
        chk("R8 ready after wait", {31'd0, ready}, 32'h1);
        @(negedge clk);
        chk("R5 no column without access", {31'd0, cas_n}, 32'h1);
        if (use_wr) wr_n = 1'b0; else rd_n = 1'b0;
        @(negedge clk);
        chk("R5 column byte", {24'd0, mem_addr}, {24'd0, a[7:0]});
        chk("R5 column strobe", {31'd0, cas_n}, 32'h0);
        chk("R4 bank strobe held", {30'd0, ras_n}, {30'd0, ras_exp});
        if (flt) begin
            rd_n = 1'b0; wr_n = 1'b0;
            @(negedge clk);
            chk("R7 float enables", {29'd0, a_oe, r_oe, c_oe}, 32'h0);
            chk("R7 cycle kept while floating", {31'd0, cas_n}, 32'h0);
            if (use_wr) rd_n = 1'b1; else wr_n = 1'b1;
            @(negedge clk);
            chk("R7 enables restored", {29'd0, a_oe, r_oe, c_oe}, 32'h7);
        end
        if (again) begin
            ale = 1'b1; cs_n = 1'b0; addr = a ^ 16'hFFFF;
            @(negedge clk);
            ale = 1'b0;
            @(negedge clk);
            @(negedge clk);
            cs_n = 1'b1;
            chk("R10 column byte kept", {24'd0, mem_addr}, {24'd0, a[7:0]});
            chk("R10 column strobe kept", {31'd0, cas_n}, 32'h0);
        end
        rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        expect_idle("R6 strobes negated");
        chk("R6 bus returns to 0", {24'd0, mem_addr}, 32'h0);
        if (again) begin
            @(negedge clk);
            @(negedge clk);
            chk("R10 no second cycle", {30'd0, ras_n}, 32'h3);
        end
    endtask

    initial begin
        rst_n = 1'b0; ale = 1'b0; cs_n = 1'b1; bank_sel = 1'b0; addr = '0;
        rd_n = 1'b1; wr_n = 1'b1; ws = 1'b0; refb = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_idle("R1 reset");
        chk("R1 reset enables", {29'd0, a_oe, r_oe, c_oe}, 32'h7);
        chk("R1 reset bus", {24'd0, mem_addr}, 32'h0);

        // Sweep bank, wait strap and read/write choice
        for (int i = 0; i < 8; i++) begin
            do_cycle(16'hA5C3 ^ 16'(i * 16'h1357), i[0], i[1], i[2], 0, 1'b0, 1'b0);
        end
        // Requests parked behind refresh for varying lengths
        for (int i = 0; i < 4; i++) begin
            do_cycle(16'h3C96 + 16'(i * 16'h0F11), i[0], i[1], ~i[0], 1 + i, 1'b0, 1'b0);
        end
        // Floating and mid-cycle latch pulses
        do_cycle(16'h8E17, 1'b0, 1'b0, 1'b0, 0, 1'b1, 1'b0);
        do_cycle(16'h51EA, 1'b1, 1'b1, 1'b1, 0, 1'b1, 1'b1);
        do_cycle(16'hFF00, 1'b0, 1'b0, 1'b1, 0, 1'b0, 1'b1);

        // R2: select low only early in the latch pulse, high at its fall
        @(negedge clk);
        ale = 1'b1; cs_n = 1'b0; addr = 16'h1234;
        @(negedge clk);
        ale = 1'b0; cs_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            expect_idle("R2 deselected request ignored");
            chk("R2 bus stays 0", {24'd0, mem_addr}, 32'h0);
        end

        // R7: floating while idle
        rd_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        chk("R7 idle float", {29'd0, a_oe, r_oe, c_oe}, 32'h0);
        chk("R7 idle float strobes", {30'd0, ras_n}, 32'h3);
        rd_n = 1'b1;
        @(negedge clk);
        chk("R7 idle drive back", {29'd0, a_oe, r_oe, c_oe}, 32'h7);
        wr_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule